// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block turns events on external trigger lines into bursts of DMA requests. It has four independent channels. Each channel watches one of 32 trigger inputs. When the programmed edge appears on that input, the channel issues a burst of requests on its own request line. Each request is held until the DMA side acknowledges it. After the last acknowledge the channel goes back to waiting for the next edge.

Software sets up each channel through one 32-bit control word per channel on a simple register port. The control word selects the trigger input, the edge sensitivity, the enable, the overrun interrupt enable and the burst length. The burst length field holds the number of requests minus one.

If a new trigger edge arrives while a burst is still running, the channel records a sticky overrun flag. That flag can raise an interrupt line. Software clears it by writing a one to the matching bit of a separate clear register.

Top module: `trgreq_gen`

## Requirements
- R1: After reset, every control word and the overrun status read as zero, and all request and interrupt outputs are low.
- R2: The control word of channel x is at byte address 0x100 + 4*x. It holds the trigger select in bits 4:0, the overrun interrupt enable in bit 8, the channel enable in bit 16, the edge mode in bits 18:17 and the burst count in bits 23:19. All other bits read as zero and ignore writes.
- R3: A write to a control word leaves the burst count field unchanged if the channel is enabled before the write. The other fields still take the written value.
- R4: With edge mode 01, a rising edge on the selected input raises the request two clock edges after the input changes. A falling edge then starts nothing.
- R5: Edge mode 10 reacts only to falling edges, and mode 11 reacts to both edges. Mode 00 ignores the trigger. A disabled channel ignores the trigger.
- R6: One trigger event produces exactly count+1 requests. Each request stays high until an acknowledge, and the request output is low in the cycle after the acknowledge.
- R7: A trigger event that arrives while the channel's burst is running sets that channel's bit in the status word at 0x140. The bit stays set until it is cleared. The channel's interrupt output is high exactly when this bit and the overrun interrupt enable are both set.
- R8: Writing 0x144 clears each status bit written with 1. Bits written with 0 are untouched. If an overrun occurs in the same cycle as a clear of that bit, the bit remains set.
- R9: Writing a control word with the enable bit at 0 ends any running burst, and the request output is low in the next cycle.
- R10: A channel reacts only to the trigger input it selects. Edges on all other inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| trig_in | input | 32 | Trigger inputs |
| req_ack | input | 4 | Per-channel request acknowledge |
| req_out | output | 4 | Per-channel DMA request |
| ovr_irq | output | 4 | Per-channel overrun interrupt |

## Verification
Two events can land in the same cycle: a trigger-driven overrun setting a status bit, and a software clear of that same bit. The bench first clears the bit while a burst is left unacknowledged. It then toggles the trigger one negative edge before issuing the clear write, so that the detected event and the write share a clock edge. The status word must then still show the bit set. A second plain clear must remove it. A disable write that lands while a request is pending is judged in the same way: the request must be low at the very next sample.

// File: rtl/trgreq_pkg.sv
package trgreq_pkg;
  localparam int SEL_W   = 5;
  localparam int CNT_W   = 5;
  localparam int ADDR_W  = 9;
  localparam int SEL_LSB = 0;
  localparam int OIE_BIT = 8;
  localparam int EN_BIT  = 16;
  localparam int POL_LSB = 17;
  localparam int CNT_LSB = 19;

  localparam logic [ADDR_W-1:0] CTRL_BASE = 9'h100;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 9'h140;
  localparam logic [ADDR_W-1:0] CLR_ADDR  = 9'h144;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    BST_IDLE = 2'b00,
    BST_REQ  = 2'b01,
    BST_GAP  = 2'b10
  } burst_st_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    edge_mode_e       mode;
    logic             en;
    logic             oie;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;

  function automatic logic [31:0] cfg_to_word(input chan_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[OIE_BIT]          = c.oie;
    w[EN_BIT]           = c.en;
    w[POL_LSB +: 2]     = c.mode;
    w[CNT_LSB +: CNT_W] = c.cnt;
    return w;
  endfunction
endpackage

// File: rtl/trgreq_edge.sv
module trgreq_edge
  import trgreq_pkg::*;
#(
  parameter int NUM_TRIG = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  input  edge_mode_e          mode,
  input  logic                en,
  output logic                evt_o
);
  logic sel_bit;
  logic smp_q, prev_q;
  logic rise, fall, hit;

  always_comb sel_bit = trig_in[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= sel_bit;
      prev_q <= smp_q;
    end
  end

  always_comb begin
    rise = smp_q & ~prev_q;
    fall = ~smp_q & prev_q;
    unique case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    evt_o = en & hit;
  end
endmodule

// File: rtl/trgreq_burst.sv
module trgreq_burst
  import trgreq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             evt,
  input  logic             ack,
  output logic             req_o,
  output logic             ovr_evt_o
);
  burst_st_e        state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    if (!en) begin
      state_d = BST_IDLE;
    end else begin
      unique case (state_q)
        BST_IDLE: if (evt) begin
          state_d = BST_REQ;
          rem_d   = cnt;
        end
        BST_REQ: if (ack) begin
          if (rem_q == '0) begin
            state_d = BST_IDLE;
          end else begin
            state_d = BST_GAP;
            rem_d   = rem_q - 1'b1;
          end
        end
        default: state_d = BST_REQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BST_IDLE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
    end
  end

  assign req_o     = (state_q == BST_REQ) & en;
  assign ovr_evt_o = evt & (state_q != BST_IDLE);
endmodule

// File: rtl/trgreq_gen.sv
module trgreq_gen
  import trgreq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_TRIG = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [NUM_CH-1:0]   req_ack,
  output logic [NUM_CH-1:0]   req_out,
  output logic [NUM_CH-1:0]   ovr_irq
);
  chan_cfg_t         cfg_q [NUM_CH];
  logic [NUM_CH-1:0] ovr_q, ovr_d;
  logic [NUM_CH-1:0] ovr_evt, oie_v;
  logic              clr_sel;

  assign clr_sel = reg_we && (reg_addr == CLR_ADDR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = CTRL_BASE + ADDR_W'(4 * i);
    logic      wr_ctrl;
    chan_cfg_t cfg_d;
    logic      evt;

    assign wr_ctrl = reg_we && (reg_addr == MY_ADDR);

    always_comb begin
      cfg_d      = cfg_q[i];
      cfg_d.sel  = reg_wdata[SEL_LSB +: SEL_W];
      cfg_d.oie  = reg_wdata[OIE_BIT];
      cfg_d.en   = reg_wdata[EN_BIT];
      cfg_d.mode = edge_mode_e'(reg_wdata[POL_LSB +: 2]);
      if (!cfg_q[i].en) cfg_d.cnt = reg_wdata[CNT_LSB +: CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q[i] <= '0;
      else if (wr_ctrl) cfg_q[i] <= cfg_d;
    end

    trgreq_edge #(.NUM_TRIG(NUM_TRIG)) edge_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_in (trig_in),
      .sel     (cfg_q[i].sel),
      .mode    (cfg_q[i].mode),
      .en      (cfg_q[i].en),
      .evt_o   (evt)
    );

    trgreq_burst burst_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_q[i].en),
      .cnt       (cfg_q[i].cnt),
      .evt       (evt),
      .ack       (req_ack[i]),
      .req_o     (req_out[i]),
      .ovr_evt_o (ovr_evt[i])
    );

    assign oie_v[i] = cfg_q[i].oie;

    always_comb begin
      if (ovr_evt[i])                   ovr_d[i] = 1'b1;
      else if (clr_sel && reg_wdata[i]) ovr_d[i] = 1'b0;
      else                              ovr_d[i] = ovr_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= '0;
    else        ovr_q <= ovr_d;
  end

  assign ovr_irq = ovr_q & oie_v;

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (reg_addr == CTRL_BASE + ADDR_W'(4 * k)) reg_rdata = cfg_to_word(cfg_q[k]);
    end
    if (reg_addr == STAT_ADDR) reg_rdata[NUM_CH-1:0] = ovr_q;
  end
endmodule

// File: rtl/trgreq_chk.sv
module trgreq_chk
  import trgreq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NUM_CH-1:0] req_ack,
  input logic [NUM_CH-1:0] req_out,
  input logic [NUM_CH-1:0] ovr_irq
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (req_out == '0 && ovr_irq == '0);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] MY_ADDR = CTRL_BASE + ADDR_W'(4 * g);

    assert_gap_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_out[g] && req_ack[g]) |=> !req_out[g]);

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_irq[g] && !reg_we) |=> ovr_irq[g]);

    assert_abort_on_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == MY_ADDR && !reg_wdata[EN_BIT]) |=> !req_out[g]);
  end
endmodule

bind trgreq_gen trgreq_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .req_ack   (req_ack),
  .req_out   (req_out),
  .ovr_irq   (ovr_irq)
);

// File: tb/trgreq_gen_tb_top.sv
`timescale 1ns/1ps
module trgreq_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] trig_in;
  logic [3:0]  req_ack;
  logic [3:0]  req_out;
  logic [3:0]  ovr_irq;

  int n_checks = 0;
  int n_err    = 0;
  logic [31:0] shadow [4];

  always #2.5 clk = ~clk;

  trgreq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .req_ack(req_ack), .req_out(req_out), .ovr_irq(ovr_irq)
  );

  function automatic logic [31:0] mk(input int sel, input bit oie, input bit en,
                                     input int mode, input int cnt);
    logic [31:0] w;
    w = '0;
    w[4:0]   = 5'(sel);
    w[8]     = oie;
    w[16]    = en;
    w[18:17] = 2'(mode);
    w[23:19] = 5'(cnt);
    return w;
  endfunction

  function automatic logic [31:0] exp_ctrl(input logic [31:0] old, input logic [31:0] w);
    logic [31:0] r;
    r = w & 32'h0007_011F;
    r[23:19] = old[16] ? old[23:19] : w[23:19];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a >= 9'h100 && a < 9'h110) shadow[(a - 9'h100) >> 2] = exp_ctrl(shadow[(a - 9'h100) >> 2], d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pump(input int ch, output int acks);
    int idle;
    idle = 0; acks = 0;
    while (idle < 6) begin
      @(negedge clk);
      if (req_out[ch]) begin
        idle = 0; req_ack[ch] = 1'b1; acks++;
        @(negedge clk);
        req_ack[ch] = 1'b0;
        check("R6 request low after ack", 32'(req_out[ch]), 32'd0);
      end else begin
        idle++;
      end
    end
  endtask

  task automatic watch_quiet(input int ch, input int n, input string tag);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen = seen | req_out[ch];
    end
    check(tag, 32'(seen), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int acks;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    trig_in = '0; req_ack = '0;
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    cycles(3);
    check("R1 req_out at reset", 32'(req_out), 32'd0);
    check("R1 ovr_irq at reset", 32'(ovr_irq), 32'd0);
    rst_n = 1'b1;
    cycles(1);
    for (int i = 0; i < 4; i++) begin
      rd(9'(9'h100 + 4 * i), d);
      check("R1 control word zero", d, 32'd0);
    end
    rd(9'h140, d);
    check("R1 status zero", d, 32'd0);

    // R2/R3: random register traffic, trigger inputs held still
    for (int it = 0; it < 40; it++) begin
      int ch;
      logic [31:0] w;
      ch = int'($urandom % 4);
      w  = $urandom;
      wr(9'(9'h100 + 4 * ch), w);
      rd(9'(9'h100 + 4 * ch), d);
      check("R2 R3 control readback", d, shadow[ch]);
    end
    // R3 directed: count locked while enabled
    wr(9'h100, 32'd0); wr(9'h100, 32'd0);
    wr(9'h100, mk(0, 0, 1, 0, 3));
    wr(9'h100, mk(9, 1, 1, 2, 7));
    rd(9'h100, d);
    check("R3 count locked while enabled", d, mk(9, 1, 1, 2, 3));
    for (int i = 0; i < 4; i++) begin
      wr(9'(9'h100 + 4 * i), 32'd0);
      wr(9'(9'h100 + 4 * i), 32'd0);
    end
    rd(9'h140, d);
    check("R5 no overrun from register traffic", d, 32'd0);

    // R4: rising latency and falling ignored
    wr(9'h104, mk(7, 0, 1, 1, 0));
    cycles(3);
    trig_in[7] = 1'b1;
    @(negedge clk);
    check("R4 no request after one edge", 32'(req_out[1]), 32'd0);
    @(negedge clk);
    check("R4 request after two edges", 32'(req_out[1]), 32'd1);
    pump(1, acks);
    check("R6 count 0 gives one request", 32'(acks), 32'd1);
    trig_in[7] = 1'b0;
    watch_quiet(1, 6, "R4 falling edge ignored in rising mode");
    // R5: falling mode
    wr(9'h104, mk(7, 0, 1, 2, 0));
    trig_in[7] = 1'b1;
    watch_quiet(1, 6, "R5 rising edge ignored in falling mode");
    trig_in[7] = 1'b0;
    pump(1, acks);
    check("R5 falling edge starts burst", 32'(acks), 32'd1);
    // R5: mode off, then disabled channel
    wr(9'h104, mk(7, 0, 1, 0, 0));
    trig_in[7] = 1'b1; cycles(3); trig_in[7] = 1'b0;
    watch_quiet(1, 6, "R5 mode 00 ignores trigger");
    wr(9'h104, mk(7, 0, 0, 3, 0));
    trig_in[7] = 1'b1; cycles(3); trig_in[7] = 1'b0;
    watch_quiet(1, 6, "R5 disabled channel ignores trigger");

    // R6/R10: constrained random bursts
    for (int it = 0; it < 10; it++) begin
      int ch, sel, mode, cnt;
      logic idle_lvl;
      ch   = int'($urandom % 4);
      sel  = int'($urandom % 32);
      mode = 1 + int'($urandom % 3);
      cnt  = int'($urandom % 8);
      idle_lvl = (mode == 2);
      trig_in = idle_lvl ? 32'hFFFF_FFFF : 32'h0;
      cycles(3);
      wr(9'(9'h100 + 4 * ch), mk(sel, 0, 1, mode, cnt));
      cycles(2);
      trig_in = trig_in ^ ~(32'd1 << sel);
      watch_quiet(ch, 5, "R10 unselected inputs ignored");
      trig_in[sel] = ~idle_lvl;
      pump(ch, acks);
      check("R6 burst length count+1", 32'(acks), 32'(cnt + 1));
      wr(9'(9'h100 + 4 * ch), 32'd0);
    end
    trig_in = '0;
    cycles(3);

    // R7/R8: overrun, clearing, same-cycle race, abort
    wr(9'h100, mk(3, 1, 1, 3, 2));
    cycles(2);
    trig_in[3] = 1'b1;
    cycles(4);
    check("R6 request held without ack", 32'(req_out[0]), 32'd1);
    trig_in[3] = 1'b0;
    cycles(3);
    rd(9'h140, d);
    check("R7 overrun status set", d, 32'd1);
    check("R7 irq with enable", 32'(ovr_irq), 32'd1);
    wr(9'h144, 32'h0000_000E);
    rd(9'h140, d);
    check("R8 clear of other bits no effect", d, 32'd1);
    wr(9'h100, mk(3, 0, 1, 3, 2));
    check("R7 irq masked by enable", 32'(ovr_irq), 32'd0);
    wr(9'h100, mk(3, 1, 1, 3, 2));
    check("R7 irq back with enable", 32'(ovr_irq), 32'd1);
    wr(9'h144, 32'h0000_0001);
    rd(9'h140, d);
    check("R8 write one clears", d, 32'd0);
    trig_in[3] = 1'b1;
    wr(9'h144, 32'h0000_0001);
    rd(9'h140, d);
    check("R8 set wins over same-cycle clear", d, 32'd1);
    wr(9'h144, 32'h0000_000F);
    rd(9'h140, d);
    check("R8 later clear works", d, 32'd0);
    check("R9 request pending before disable", 32'(req_out[0]), 32'd1);
    wr(9'h100, mk(3, 1, 0, 3, 2));
    check("R9 request dropped after disable", 32'(req_out[0]), 32'd0);
    watch_quiet(0, 4, "R9 burst stays aborted");

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule